// File: doc/BRIEF.md
# Row-Parallel Compute-in-Memory Array

This block is a digital behavioural model of a bit-parallel memory that can compute. It holds 64 rows, each 320 bits wide. A row is split into five 64-bit words that sit in slots 0 to 4. Alongside plain 32-bit reads and writes, it has a set of row-wide commands:

- Two rows are sensed together to form their bitwise OR and AND, and the XOR is derived from those two. The chosen result goes back to a third row.
- Every 64-bit word of a row can be rotated right.
- A single word can be moved from one slot to another.
- A single word can be replicated into every slot of a row.

A controller issues one command at a time with a valid/ready pair. Every command is accepted on one clock edge and completes on the next edge. On completion the block gives a one-cycle done pulse, and with it an error flag and, for reads, the read data.

Top module: `cim_array`

## Requirements
- R1: After reset, `done` and `err` are 0, `rdData` is 0 and `cmdReady` is 1.
- R2: Op code 1 (write) stores `wrData` into 32-bit chunk `chunkSel` (0..9) of row `dstRow`; chunk k is row bits [32k+31:32k], and slot s is bits [64s+63:64s]. Op code 0 (read) returns chunk `chunkSel` of row `srcRowA` on `rdData`.
- R3: Op code 2 (logic) reads rows `srcRowA` and `srcRowB` and writes to `dstRow` their bitwise OR when `logicSel`=0, their AND when it is 1, or their XOR when it is 2.
- R4: When the destination row equals a source row, the stored result is computed from the row values as they were before the write-back.
- R5: Op code 3 (rotate) writes to `dstRow` the row `srcRowA` with each of its five 64-bit words rotated right by `rotAmt` (0..63) bit positions; a rotation by 0 copies the row unchanged.
- R6: Op code 4 (copy) writes word slot `slotFrom` of row `srcRowA` into word slot `slotTo` of row `dstRow`, leaving the other four slots of `dstRow` unchanged.
- R7: Op code 5 (broadcast) writes word slot `slotFrom` of row `srcRowA` into all five slots of `dstRow`.
- R8: A command is accepted on a clock edge where `cmdValid` and `cmdReady` are both 1. `cmdReady` is then 0 for one cycle. The result, including the updated memory and `rdData`, appears at the second edge, together with a `done` pulse exactly one cycle long.
- R9: A command is rejected if any of these holds:
  - a row it uses is 64 or above;
  - a slot it uses is 5 or above;
  - its chunk is 10 or above;
  - its `logicSel` is 3;
  - its op code is 6 or 7.
  A rejected command changes no row and leaves `rdData` as it was. It still completes with `done`, and `err` is 1.
- R10: `err` keeps its value between `done` pulses and is cleared by the next command that completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block can accept a command |
| cmdOp | input | 3 | Op code: 0 read, 1 write, 2 logic, 3 rotate, 4 copy, 5 broadcast |
| logicSel | input | 2 | Logic result: 0 OR, 1 AND, 2 XOR |
| srcRowA | input | 7 | First source row |
| srcRowB | input | 7 | Second source row (logic only) |
| dstRow | input | 7 | Destination row |
| rotAmt | input | 6 | Right-rotate amount per word |
| slotFrom | input | 3 | Source word slot |
| slotTo | input | 3 | Destination word slot (copy) |
| chunkSel | input | 4 | 32-bit chunk index for read/write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, updated by a successful read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last completed command was rejected |

## Verification
Each result is due at the second rising edge after acceptance: `done`, `err`, `rdData` and the contents of the memory all change at that edge. The driver records the cycle number of acceptance and queues the expected completion cycle, `rdData` and `err`. The monitor samples on falling edges and pops a queued item only when `done` is high, so a pulse that is early, late or stretched is reported. Memory contents are observed only by issuing reads after each operation and checking them against a bench-side row model.

// File: rtl/cim_pkg.sv
package cim_pkg;
  localparam int ROWS       = 64;
  localparam int ROW_IDX_W  = $clog2(ROWS);
  localparam int ROW_ADDR_W = ROW_IDX_W + 1;
  localparam int WORD_W     = 64;
  localparam int SLOTS      = 5;
  localparam int ROW_W      = WORD_W * SLOTS;
  localparam int BUS_W      = 32;
  localparam int CHUNKS     = ROW_W / BUS_W;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int CHUNK_W    = $clog2(CHUNKS);
  localparam int SHAMT_W    = $clog2(WORD_W);

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_LOGIC = 3'd2,
    OP_ROT   = 3'd3,
    OP_COPY  = 3'd4,
    OP_BCAST = 3'd5
  } cim_op_e;

  typedef enum logic [1:0] {
    SEL_OR  = 2'd0,
    SEL_AND = 2'd1,
    SEL_XOR = 2'd2
  } cim_sel_e;

  typedef struct packed {
    cim_op_e                 op;
    cim_sel_e                sel;
    logic [ROW_ADDR_W-1:0]   srcA;
    logic [ROW_ADDR_W-1:0]   srcB;
    logic [ROW_ADDR_W-1:0]   dst;
    logic [SHAMT_W-1:0]      shamt;
    logic [SLOT_W-1:0]       slotFrom;
    logic [SLOT_W-1:0]       slotTo;
    logic [CHUNK_W-1:0]      chunk;
    logic [BUS_W-1:0]        wdata;
  } cim_cmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                    capture;
    logic                    commit;
    logic                    ok;
    logic [ROW_IDX_W-1:0]    peekA;
    logic [ROW_IDX_W-1:0]    peekB;
    cim_cmd_t                cmd;
  } cim_strobe_t;
endpackage

// File: rtl/cim_ctrl.sv
module cim_ctrl
  import cim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  cim_cmd_t    cmdIn,
  output logic        cmdReady,
  output cim_strobe_t stb,
  output logic        done,
  output logic        err
);
  localparam logic [ROW_ADDR_W-1:0] ROW_LIM   = ROW_ADDR_W'(ROWS);
  localparam logic [SLOT_W-1:0]     SLOT_LIM  = SLOT_W'(SLOTS);
  localparam logic [CHUNK_W-1:0]    CHUNK_LIM = CHUNK_W'(CHUNKS);

  logic     busy;
  logic     okQ;
  logic     cmdOk;
  logic     capture;
  cim_cmd_t cmdQ;

  assign capture  = cmdValid && !busy;
  assign cmdReady = !busy;

  // range and encoding check on the incoming command
  always_comb begin
    cmdOk = 1'b0;
    case (cmdIn.op)
      OP_READ:  cmdOk = (cmdIn.srcA < ROW_LIM) && (cmdIn.chunk < CHUNK_LIM);
      OP_WRITE: cmdOk = (cmdIn.dst < ROW_LIM) && (cmdIn.chunk < CHUNK_LIM);
      OP_LOGIC: cmdOk = (cmdIn.srcA < ROW_LIM) && (cmdIn.srcB < ROW_LIM) &&
                        (cmdIn.dst < ROW_LIM) &&
                        (cmdIn.sel == SEL_OR || cmdIn.sel == SEL_AND || cmdIn.sel == SEL_XOR);
      OP_ROT:   cmdOk = (cmdIn.srcA < ROW_LIM) && (cmdIn.dst < ROW_LIM);
      OP_COPY:  cmdOk = (cmdIn.srcA < ROW_LIM) && (cmdIn.dst < ROW_LIM) &&
                        (cmdIn.slotFrom < SLOT_LIM) && (cmdIn.slotTo < SLOT_LIM);
      OP_BCAST: cmdOk = (cmdIn.srcA < ROW_LIM) && (cmdIn.dst < ROW_LIM) &&
                        (cmdIn.slotFrom < SLOT_LIM);
      default:  cmdOk = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      okQ  <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
      cmdQ <= '0;
    end else begin
      done <= 1'b0;
      if (capture) begin
        busy <= 1'b1;
        okQ  <= cmdOk;
        cmdQ <= cmdIn;
      end else if (busy) begin
        busy <= 1'b0;
        done <= 1'b1;
        err  <= !okQ;
      end
    end
  end

  always_comb begin
    stb.capture = capture;
    stb.commit  = busy;
    stb.ok      = okQ;
    stb.peekA   = cmdIn.srcA[ROW_IDX_W-1:0];
    stb.peekB   = cmdIn.srcB[ROW_IDX_W-1:0];
    stb.cmd     = cmdQ;
  end
endmodule

// File: rtl/cim_datapath.sv
module cim_datapath
  import cim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cim_strobe_t       stb,
  output logic [BUS_W-1:0]  rdData
);
  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] rowA;
  logic [ROW_W-1:0] rowB;
  logic [ROW_W-1:0] orV, andV, xorV, logicRes;
  logic [ROW_W-1:0] rotRow;
  logic [WORD_W-1:0] pickWord;
  logic [ROW_IDX_W-1:0] dIdx;
  logic doWrite;

  // two-row sense: OR and AND, XOR derived from them
  assign orV  = rowA | rowB;
  assign andV = rowA & rowB;
  assign xorV = orV & ~andV;

  always_comb begin
    case (stb.cmd.sel)
      SEL_AND: logicRes = andV;
      SEL_XOR: logicRes = xorV;
      default: logicRes = orV;
    endcase
  end

  // per-word right rotation, one rotator per slot
  for (genvar s = 0; s < SLOTS; s++) begin : g_rot
    logic [2*WORD_W-1:0] dbl;
    assign dbl = {rowA[s*WORD_W +: WORD_W], rowA[s*WORD_W +: WORD_W]} >> stb.cmd.shamt;
    assign rotRow[s*WORD_W +: WORD_W] = dbl[WORD_W-1:0];
  end

  assign pickWord = rowA[int'(stb.cmd.slotFrom) * WORD_W +: WORD_W];
  assign dIdx     = stb.cmd.dst[ROW_IDX_W-1:0];
  assign doWrite  = stb.commit && stb.ok;

  // read stage: capture both source rows when a command is accepted
  always_ff @(posedge clk) begin
    if (stb.capture) begin
      rowA <= mem[stb.peekA];
      rowB <= mem[stb.peekB];
    end
  end

  // write-back stage
  always_ff @(posedge clk) begin
    if (doWrite) begin
      case (stb.cmd.op)
        OP_WRITE: mem[dIdx][int'(stb.cmd.chunk) * BUS_W +: BUS_W] <= stb.cmd.wdata;
        OP_LOGIC: mem[dIdx] <= logicRes;
        OP_ROT:   mem[dIdx] <= rotRow;
        OP_COPY:  mem[dIdx][int'(stb.cmd.slotTo) * WORD_W +: WORD_W] <= pickWord;
        OP_BCAST: mem[dIdx] <= {SLOTS{pickWord}};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (doWrite && stb.cmd.op == OP_READ) begin
      rdData <= rowA[int'(stb.cmd.chunk) * BUS_W +: BUS_W];
    end
  end
endmodule

// File: rtl/cim_array.sv
module cim_array
  import cim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  output logic        cmdReady,
  input  logic [2:0]  cmdOp,
  input  logic [1:0]  logicSel,
  input  logic [6:0]  srcRowA,
  input  logic [6:0]  srcRowB,
  input  logic [6:0]  dstRow,
  input  logic [5:0]  rotAmt,
  input  logic [2:0]  slotFrom,
  input  logic [2:0]  slotTo,
  input  logic [3:0]  chunkSel,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        done,
  output logic        err
);
  cim_cmd_t    cmdIn;
  cim_strobe_t stb;

  always_comb begin
    cmdIn.op       = cim_op_e'(cmdOp);
    cmdIn.sel      = cim_sel_e'(logicSel);
    cmdIn.srcA     = srcRowA;
    cmdIn.srcB     = srcRowB;
    cmdIn.dst      = dstRow;
    cmdIn.shamt    = rotAmt;
    cmdIn.slotFrom = slotFrom;
    cmdIn.slotTo   = slotTo;
    cmdIn.chunk    = chunkSel;
    cmdIn.wdata    = wrData;
  end

  cim_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdIn    (cmdIn),
    .cmdReady (cmdReady),
    .stb      (stb),
    .done     (done),
    .err      (err)
  );

  cim_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdData (rdData)
  );
endmodule

// File: rtl/cim_array_chk.sv
module cim_array_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic [31:0] rdData,
  input logic        done,
  input logic        err
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_timing_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> (!cmdReady && !done) ##1 done);

  assert_ready_at_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cmdReady);

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(rdData));

  assert_rd_kept_on_error_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> $stable(rdData));

  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(err));
endmodule

bind cim_array cim_array_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .rdData   (rdData),
  .done     (done),
  .err      (err)
);

// File: tb/cim_array_bench.sv
module cim_array_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOp = '0;
  logic [1:0]  logicSel = '0;
  logic [6:0]  srcRowA = '0, srcRowB = '0, dstRow = '0;
  logic [5:0]  rotAmt = '0;
  logic [2:0]  slotFrom = '0, slotTo = '0;
  logic [3:0]  chunkSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        done, err;

  always #2 clk = ~clk;  // 250 MHz

  cim_array u_cim_array (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .logicSel(logicSel), .srcRowA(srcRowA), .srcRowB(srcRowB),
    .dstRow(dstRow), .rotAmt(rotAmt), .slotFrom(slotFrom), .slotTo(slotTo),
    .chunkSel(chunkSel), .wrData(wrData), .rdData(rdData), .done(done), .err(err)
  );

  typedef struct {
    int          doneCyc;
    bit          chkRd;
    logic [31:0] rd;
    bit          errExp;
    string       tag;
  } item_t;

  item_t       sbq[$];
  bit [319:0]  model [64];
  logic [31:0] lastRd = '0;
  int          cyc = 0;
  int          nChecks = 0;
  int          nFail = 0;
  bit          finished = 1'b0;
  bit          prevDone = 1'b0;

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      finishRun();
    end
  end

  // monitor: pop and compare on each done pulse
  always @(negedge clk) begin
    if (rstN) begin
      if (done && prevDone) chk(1'b0, "R8 done longer than one cycle", 32'(done), 32'd0);
      if (done && !prevDone) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = sbq.pop_front();
          chk(cyc == it.doneCyc, {it.tag, " done cycle"}, 32'(cyc), 32'(it.doneCyc));
          chk(err == it.errExp, {it.tag, " err"}, 32'(err), 32'(it.errExp));
          if (it.chkRd) chk(rdData === it.rd, {it.tag, " rdData"}, rdData, it.rd);
        end
      end
      prevDone = done;
    end
  end

  task automatic issue(input logic [2:0] op, input logic [1:0] sel,
                       input logic [6:0] a, input logic [6:0] b, input logic [6:0] d,
                       input logic [5:0] sh, input logic [2:0] sf, input logic [2:0] st,
                       input logic [3:0] ch, input logic [31:0] wd,
                       input bit chkRd, input logic [31:0] expRd, input bit expErr,
                       input string tag);
    item_t it;
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdOp = op; logicSel = sel; srcRowA = a; srcRowB = b; dstRow = d;
    rotAmt = sh; slotFrom = sf; slotTo = st; chunkSel = ch; wrData = wd;
    cmdValid = 1'b1;
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
    it.doneCyc = cyc + 1; it.chkRd = chkRd; it.rd = expRd; it.errExp = expErr; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    chk(cmdReady == 1'b0, "R8 ready low after accept", 32'(cmdReady), 32'd0);
  endtask

  function automatic logic [31:0] pat(int r, int k);
    logic [31:0] v;
    v = 32'(r * 16 + k + 1);
    return (v * 32'h9E3779B9) ^ {v[15:0], 16'hA5C3};
  endfunction

  task automatic wrChunk(int r, int k, logic [31:0] d);
    issue(3'd1, 2'd0, 7'd0, 7'd0, 7'(r), 6'd0, 3'd0, 3'd0, 4'(k), d, 1'b0, '0, 1'b0, "R2 write");
    model[r][32*k +: 32] = d;
  endtask

  task automatic rdChunk(int r, int k, string tag);
    lastRd = model[r][32*k +: 32];
    issue(3'd0, 2'd0, 7'(r), 7'd0, 7'd0, 6'd0, 3'd0, 3'd0, 4'(k), '0, 1'b1, lastRd, 1'b0, tag);
  endtask

  task automatic rdRow(int r, string tag);
    for (int k = 0; k < 10; k++) rdChunk(r, k, tag);
  endtask

  task automatic fillRow(int r);
    for (int k = 0; k < 10; k++) wrChunk(r, k, pat(r, k));
  endtask

  task automatic logicOp(int sel, int a, int b, int d);
    bit [319:0] x, y;
    x = model[a]; y = model[b];
    issue(3'd2, 2'(sel), 7'(a), 7'(b), 7'(d), 6'd0, 3'd0, 3'd0, 4'd0, '0, 1'b0, '0, 1'b0, "R3 logic");
    case (sel)
      0: model[d] = x | y;
      1: model[d] = x & y;
      default: model[d] = x ^ y;
    endcase
  endtask

  task automatic rotOp(int a, int d, int sh);
    bit [319:0] src, res;
    src = model[a];
    for (int s = 0; s < 5; s++)
      for (int bi = 0; bi < 64; bi++)
        res[s*64 + bi] = src[s*64 + ((bi + sh) % 64)];
    issue(3'd3, 2'd0, 7'(a), 7'd0, 7'(d), 6'(sh), 3'd0, 3'd0, 4'd0, '0, 1'b0, '0, 1'b0, "R5 rotate");
    model[d] = res;
  endtask

  task automatic badCmd(logic [2:0] op, logic [1:0] sel, logic [6:0] a, logic [6:0] b,
                        logic [6:0] d, logic [2:0] sf, logic [2:0] st, logic [3:0] ch, string tag);
    issue(op, sel, a, b, d, 6'd5, sf, st, ch, 32'hDEAD_BEEF, 1'b1, lastRd, 1'b1, tag);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", 32'(done), 32'd0);
    chk(err == 1'b0, "R1 err after reset", 32'(err), 32'd0);
    chk(rdData == 32'd0, "R1 rdData after reset", rdData, 32'd0);
    chk(cmdReady == 1'b1, "R1 ready after reset", 32'(cmdReady), 32'd1);

    fillRow(0); fillRow(1); fillRow(2); fillRow(3); fillRow(11); fillRow(12);
    rdRow(0, "R2 read row0");
    wrChunk(63, 9, 32'h1234_5678);
    rdChunk(63, 9, "R2 last row last chunk");

    logicOp(0, 0, 1, 5); rdRow(5, "R3 OR");
    logicOp(1, 0, 1, 6); rdRow(6, "R3 AND");
    logicOp(2, 0, 1, 7); rdRow(7, "R3 XOR");

    logicOp(2, 0, 1, 0); rdRow(0, "R4 dst equals srcA");
    logicOp(1, 2, 2, 2); rdRow(2, "R4 dst equals both sources");

    rotOp(1, 8, 13); rdRow(8, "R5 rotate 13");
    rotOp(1, 9, 0);  rdRow(9, "R5 rotate 0");
    rotOp(1, 10, 63); rdRow(10, "R5 rotate 63");

    issue(3'd4, 2'd0, 7'd2, 7'd0, 7'd11, 6'd0, 3'd4, 3'd0, 4'd0, '0, 1'b0, '0, 1'b0, "R6 copy");
    model[11][0 +: 64] = model[2][256 +: 64];
    rdRow(11, "R6 copy result");

    issue(3'd5, 2'd0, 7'd0, 7'd0, 7'd12, 6'd0, 3'd1, 3'd0, 4'd0, '0, 1'b0, '0, 1'b0, "R7 broadcast");
    model[12] = {5{model[0][64 +: 64]}};
    rdRow(12, "R7 broadcast result");

    rdChunk(3, 4, "R9 reference read");
    badCmd(3'd0, 2'd0, 7'd64, 7'd0, 7'd0, 3'd0, 3'd0, 4'd0, "R9 read row 64");
    drain();
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R10 err held while idle", 32'(err), 32'd1);
    badCmd(3'd1, 2'd0, 7'd0, 7'd0, 7'd3, 3'd0, 3'd0, 4'd10, "R9 write chunk 10");
    badCmd(3'd2, 2'd0, 7'd0, 7'd70, 7'd3, 3'd0, 3'd0, 4'd0, "R9 logic srcB 70");
    badCmd(3'd2, 2'd3, 7'd0, 7'd1, 7'd3, 3'd0, 3'd0, 4'd0, "R9 logic sel 3");
    badCmd(3'd4, 2'd0, 7'd0, 7'd0, 7'd3, 3'd0, 3'd5, 4'd0, "R9 copy slot 5");
    badCmd(3'd5, 2'd0, 7'd0, 7'd0, 7'd127, 3'd0, 3'd0, 4'd0, "R9 broadcast row 127");
    badCmd(3'd6, 2'd0, 7'd0, 7'd0, 7'd3, 3'd0, 3'd0, 4'd0, "R9 op 6");
    rdRow(3, "R9 R10 row untouched and err cleared");

    drain();
    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R8 all results delivered", 32'(sbq.size()), 32'd0);
    finishRun();
  end
endmodule